// File: doc/BRIEF.md
# Note Tone Square-Wave Generator

This block drives a single audio pin with a square tone whose repetition length is given directly as a period word. The period counts pulses of a counter strobe (`tone_tick`). That strobe comes from a divider elsewhere, usually at 100 kHz, so a period of N ticks gives a tone of 100 kHz / N. The frequency-to-period arithmetic is done upstream; the block only consumes the finished period word. The share of each period spent high comes from a timbre percentage: the pin is high for (100 − timbre) percent of the period, and a timbre above 100 counts as 100.

Requests are not taken at once. An internal update timer of `UPD_CYCLES` system clocks (about 16 ms in a real chip) samples the request inputs. When the rest flag is set, or the period word is not usable, the sample leaves the running tone exactly as it was. An accepted request waits in a pending slot and replaces the running tone only when the phase counter wraps, so no shortened pulse ever appears on the pin.

Raising `play_en` starts the channel from a fixed two-tick period and re-arms the update timer from zero. Dropping it silences the pin at once and cancels the timer, so each new start begins from the same known state.

Top module: `tone_gen_top`

## Requirements
- R1: After reset, `tone_out` and `busy` are 0.
- R2: The phase counter advances only on cycles where `tone_tick` is 1, and the output pattern repeats every P strobes, where P is the active period.
- R3: The output is high for floor(P*(100−T)/100) strobes at the start of each period, with T the timbre clamped to 100. T=0 gives a constant high and T≥100 a constant low.
- R4: An update sample taken while `rest` is 1, or while `note_period` is below 2, leaves the active period and high time unchanged.
- R5: After a start, the active period is 2 strobes with 1 high strobe, until the first accepted request takes effect.
- R6: Requests are sampled only on the internal update tick. The first tick comes UPD_CYCLES clocks after the start, and later ticks follow every UPD_CYCLES clocks.
- R7: A new period and high time become active only at a period boundary, with the phase counter at 0.
- R8: While `play_en` is 0, `tone_out` is 0 in the same cycle. `busy` falls one clock later, the update timer is cleared, and raising `play_en` again restarts from R5.
- R9: `busy` is 1 from the clock after `play_en` rises until the clock after it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| play_en | input | 1 | Playback enable; a rising edge restarts the channel |
| tone_tick | input | 1 | Counter strobe that advances the tone phase |
| note_period | input | PW | Requested period in strobes (below 2 is ignored) |
| timbre_pct | input | 7 | Timbre percentage; high share is 100 minus this |
| rest | input | 1 | Rest request; keeps the current tone settings |
| tone_out | output | 1 | Square-wave tone pin |
| busy | output | 1 | Channel running |

## Verification
The bench builds the block with an 8-bit period word and a 20-cycle update interval. With these values, every update tick, start sequence and period change fits in a few hundred clocks. This makes a full grid of periods from 2 up to 25 against timbres from 0 to beyond 100 affordable, with each period and high time measured edge to edge at the pin. A divided strobe run checks that only strobes advance the phase. The short interval also makes the two-tick start phase and the rest and invalid-period holds easy to observe directly.

// File: rtl/tone_gen_pkg.sv
package tone_gen_pkg;
   localparam int PCT_W   = 7;
   localparam int PCT_MAX = 100;

   function automatic logic [PCT_W-1:0] pct_clamp(input logic [PCT_W-1:0] p);
      return (p > PCT_W'(PCT_MAX)) ? PCT_W'(PCT_MAX) : p;
   endfunction
endpackage

// File: rtl/tone_upd_timer.sv
module tone_upd_timer #(
   parameter int UPD_CYCLES = 800000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic fire
);
   localparam int CW = $clog2(UPD_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(UPD_CYCLES - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run)           cnt <= '0;
      else if (cnt == LAST)    cnt <= '0;
      else                     cnt <= cnt + 1'b1;
   end

   assign fire = run && (cnt == LAST);
endmodule

// File: rtl/tone_duty_calc.sv
module tone_duty_calc
   import tone_gen_pkg::*;
#(
   parameter int PW = 16
) (
   input  logic [PW-1:0]    period,
   input  logic [PCT_W-1:0] pct,
   output logic [PW-1:0]    high_ticks
);
   localparam int MW = PW + PCT_W;

   logic [PCT_W-1:0] keep_pct;
   logic [MW-1:0]    prod;
   logic [MW-1:0]    quot;

   always_comb begin
      keep_pct   = PCT_W'(PCT_MAX) - pct_clamp(pct);
      prod       = MW'(period) * MW'(keep_pct);
      quot       = prod / MW'(PCT_MAX);
      high_ticks = quot[PW-1:0];
   end
endmodule

// File: rtl/tone_phase_gen.sv
module tone_phase_gen #(
   parameter int PW          = 16,
   parameter int INIT_PERIOD = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          tick,
   input  logic          ld_vld,
   input  logic [PW-1:0] ld_per,
   input  logic [PW-1:0] ld_high,
   output logic          active,
   output logic [PW-1:0] ph,
   output logic [PW-1:0] cur_per,
   output logic [PW-1:0] cur_high,
   output logic          wave
);
   localparam logic [PW-1:0] P0 = PW'(INIT_PERIOD);
   localparam logic [PW-1:0] H0 = PW'(INIT_PERIOD / 2);

   logic          pend_vld;
   logic [PW-1:0] pend_per;
   logic [PW-1:0] pend_high;
   logic          wrap;

   assign wrap = tick && (ph == cur_per - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         ph        <= '0;
         cur_per   <= P0;
         cur_high  <= H0;
         pend_vld  <= 1'b0;
         pend_per  <= P0;
         pend_high <= H0;
      end else if (!run || !active) begin
         active    <= run;
         ph        <= '0;
         cur_per   <= P0;
         cur_high  <= H0;
         pend_vld  <= 1'b0;
      end else begin
         if (ld_vld) begin
            pend_per  <= ld_per;
            pend_high <= ld_high;
         end
         if (wrap) begin
            ph <= '0;
            if (pend_vld) begin
               cur_per  <= pend_per;
               cur_high <= pend_high;
            end
         end else if (tick) begin
            ph <= ph + 1'b1;
         end
         if (ld_vld)                pend_vld <= 1'b1;
         else if (wrap && pend_vld) pend_vld <= 1'b0;
      end
   end

   assign wave = active && (ph < cur_high);
endmodule

// File: rtl/tone_gen_top.sv
module tone_gen_top
   import tone_gen_pkg::*;
#(
   parameter int PW          = 16,
   parameter int UPD_CYCLES  = 800000,
   parameter int INIT_PERIOD = 2,
   parameter bit DUTY_PIPE   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             play_en,
   input  logic             tone_tick,
   input  logic [PW-1:0]    note_period,
   input  logic [PCT_W-1:0] timbre_pct,
   input  logic             rest,
   output logic             tone_out,
   output logic             busy
);
   localparam logic [PW-1:0] MIN_PER = PW'(2);

   generate
      if (PW < 2)          begin : g_bad_pw   $error("PW must be at least 2"); end
      if (UPD_CYCLES < 2)  begin : g_bad_upd  $error("UPD_CYCLES must be at least 2"); end
      if (INIT_PERIOD < 2 || INIT_PERIOD >= (1 << PW))
                           begin : g_bad_init $error("INIT_PERIOD out of range"); end
   endgenerate

   logic          active;
   logic          upd_fire;
   logic          req_ok;
   logic [PW-1:0] req_high;
   logic          ld_vld;
   logic [PW-1:0] ld_per;
   logic [PW-1:0] ld_high;
   logic [PW-1:0] ph;
   logic [PW-1:0] cur_per;
   logic [PW-1:0] cur_high;
   logic          wave;

   tone_upd_timer #(.UPD_CYCLES(UPD_CYCLES)) timer_i (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (active),
      .fire  (upd_fire)
   );

   tone_duty_calc #(.PW(PW)) duty_i (
      .period     (note_period),
      .pct        (timbre_pct),
      .high_ticks (req_high)
   );

   assign req_ok = upd_fire && play_en && !rest && (note_period >= MIN_PER);

   generate
      if (DUTY_PIPE) begin : g_pipe
         logic          q_vld;
         logic [PW-1:0] q_per;
         logic [PW-1:0] q_high;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_vld  <= 1'b0;
               q_per  <= '0;
               q_high <= '0;
            end else begin
               q_vld  <= req_ok;
               q_per  <= note_period;
               q_high <= req_high;
            end
         end
         assign ld_vld  = q_vld;
         assign ld_per  = q_per;
         assign ld_high = q_high;
      end else begin : g_direct
         assign ld_vld  = req_ok;
         assign ld_per  = note_period;
         assign ld_high = req_high;
      end
   endgenerate

   tone_phase_gen #(.PW(PW), .INIT_PERIOD(INIT_PERIOD)) phase_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (play_en),
      .tick     (tone_tick),
      .ld_vld   (ld_vld),
      .ld_per   (ld_per),
      .ld_high  (ld_high),
      .active   (active),
      .ph       (ph),
      .cur_per  (cur_per),
      .cur_high (cur_high),
      .wave     (wave)
   );

   assign tone_out = play_en && wave;
   assign busy     = active;
endmodule

// File: rtl/tone_gen_chk.sv
module tone_gen_chk #(
   parameter int PW          = 16,
   parameter int INIT_PERIOD = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          play_en,
   input logic          tone_tick,
   input logic          tone_out,
   input logic          active,
   input logic [PW-1:0] ph,
   input logic [PW-1:0] cur_per,
   input logic [PW-1:0] cur_high
);
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   p_silent_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !play_en |-> !tone_out);

   p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (ph < cur_per));

   p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && active && !tone_tick) |=> (!active || !$past(active) || $stable(ph)));

   p_high_fits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cur_high <= cur_per);

   p_start_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && active && !$past(active)) |-> (cur_per == PW'(INIT_PERIOD)));

   p_boundary_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && active && $past(active) && (cur_per != $past(cur_per) || cur_high != $past(cur_high)))
      |-> (ph == '0));
endmodule

bind tone_gen_top tone_gen_chk #(.PW(PW), .INIT_PERIOD(INIT_PERIOD)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .play_en   (play_en),
   .tone_tick (tone_tick),
   .tone_out  (tone_out),
   .active    (active),
   .ph        (ph),
   .cur_per   (cur_per),
   .cur_high  (cur_high)
);

// File: tb/tone_gen_top_tb_top.sv
module tone_gen_top_tb_top;
   localparam int PW  = 8;
   localparam int UPD = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          play_en = 1'b0;
   logic          tone_tick;
   logic [PW-1:0] note_period = 8'd2;
   logic [6:0]    timbre_pct = 7'd50;
   logic          rest = 1'b0;
   logic          tone_out;
   logic          busy;

   int n_chk = 0;
   int n_bad = 0;
   int tick_div = 1;
   int tick_cnt = 0;

   always #10 clk = ~clk;

   always @(negedge clk) begin
      tick_cnt = (tick_cnt + 1 >= tick_div) ? 0 : tick_cnt + 1;
   end
   assign tone_tick = (tick_cnt == 0);

   tone_gen_top #(.PW(PW), .UPD_CYCLES(UPD), .INIT_PERIOD(2), .DUTY_PIPE(1'b0)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .play_en     (play_en),
      .tone_tick   (tone_tick),
      .note_period (note_period),
      .timbre_pct  (timbre_pct),
      .rest        (rest),
      .tone_out    (tone_out),
      .busy        (busy)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_high(input int p, input int t);
      int tc = (t > 100) ? 100 : t;
      return (p * (100 - tc)) / 100;
   endfunction

   task automatic settle(input int cyc);
      repeat (cyc) @(negedge clk);
   endtask

   // measures period and high time in clock cycles at the pin
   task automatic measure(input int per, input int hi, input string req);
      int n;
      int h;
      int prev;
      int guard;
      if (hi == 0 || hi == per) begin
         int bad = 0;
         for (int k = 0; k < 3 * per; k++) begin
            @(negedge clk);
            if (tone_out != (hi != 0)) bad++;
         end
         check(bad == 0, req, bad, 0);
      end else begin
         prev = 1; guard = 0;
         while (!(prev == 0 && tone_out == 1) && guard < 2000) begin
            prev = tone_out; @(negedge clk); guard++;
         end
         n = 1; h = 1; prev = 1; guard = 0;
         forever begin
            @(negedge clk);
            guard++;
            if ((prev == 0 && tone_out == 1) || guard > 2000) break;
            h += tone_out;
            n++;
            prev = tone_out;
         end
         check(n == per, {req, " period"}, n, per);
         check(h == hi,  {req, " high"},   h, hi);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      int bad;
      int periods[6] = '{2, 3, 4, 7, 10, 25};
      int timbres[7] = '{0, 10, 33, 50, 90, 100, 127};

      settle(3);
      check(tone_out == 0 && busy == 0, "R1 reset outputs", {tone_out, busy}, 0);
      rst_n = 1'b1;
      settle(2);

      // R5/R6/R9: start with a valid request, initial two-tick tone until first update
      note_period = 8'd7; timbre_pct = 7'd0;
      play_en = 1'b1;
      @(negedge clk);
      check(busy == 1, "R9 busy after start", busy, 1);
      bad = 0;
      for (int k = 0; k < UPD - 2; k++) begin
         if (tone_out != ((k % 2) == 0)) bad++;
         @(negedge clk);
      end
      check(bad == 0, "R5 R6 initial two-tick tone", bad, 0);
      settle(UPD + 20);
      measure(7, 7, "R6 first request applied");

      // R2 R3: sweep of periods and timbres
      foreach (periods[i]) begin
         foreach (timbres[j]) begin
            note_period = PW'(periods[i]);
            timbre_pct  = 7'(timbres[j]);
            settle(UPD + 60);
            measure(periods[i], exp_high(periods[i], timbres[j]), "R2 R3 sweep");
         end
      end

      // R2: strobe every third cycle
      tick_div = 3;
      note_period = 8'd5; timbre_pct = 7'd40;
      settle(UPD + 60);
      measure(15, 9, "R2 divided strobe");
      tick_div = 1;

      // R4: rest keeps current tone
      note_period = 8'd10; timbre_pct = 7'd50;
      settle(UPD + 40);
      measure(10, 5, "R4 before rest");
      rest = 1'b1; note_period = 8'd4; timbre_pct = 7'd0;
      settle(3 * UPD);
      measure(10, 5, "R4 rest holds");
      rest = 1'b0; note_period = 8'd1;
      settle(3 * UPD);
      measure(10, 5, "R4 short period ignored");
      note_period = 8'd0;
      settle(3 * UPD);
      measure(10, 5, "R4 zero period ignored");

      // R8: stop silences pin at once, busy falls next clock
      note_period = 8'd10; timbre_pct = 7'd0;
      settle(UPD + 40);
      play_en = 1'b0;
      #1;
      check(tone_out == 0, "R8 pin low same cycle", tone_out, 0);
      @(negedge clk);
      check(busy == 0, "R8 R9 busy low", busy, 0);
      bad = 0;
      for (int k = 0; k < 2 * UPD; k++) begin
         @(negedge clk);
         if (tone_out != 0 || busy != 0) bad++;
      end
      check(bad == 0, "R8 silent while disabled", bad, 0);

      // R8 R5: restart begins from two-tick tone again
      play_en = 1'b1;
      @(negedge clk);
      bad = 0;
      for (int k = 0; k < UPD - 2; k++) begin
         if (tone_out != ((k % 2) == 0)) bad++;
         @(negedge clk);
      end
      check(bad == 0, "R8 R5 restart two-tick tone", bad, 0);
      settle(UPD + 40);
      measure(10, 10, "R6 R7 request after restart");

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule